// File: doc/BRIEF.md
# Indexed Event Counter Bank with Threshold Interrupts

This block holds a small bank of wide event counters behind one narrow register window. Software first writes an index register to pick a counter. Every later access to a count, an event condition or a threshold then goes to that counter. Each counter watches one of a vector of event-condition inputs. It advances by one in every cycle in which that input is high.

Each counter also has a threshold. When an increment lands exactly on the threshold and the counter's interrupt enable is set, the counter raises a sticky active flag. The combined interrupt line is high while any active flag is set. Software clears a flag by writing one to its bit, and that same write also drops the counter's enable, so the counter has to be re-armed by hand.

A command register clears every count at once, or copies every live count into a snapshot. Software reads counts only from the snapshot. A read-only build word describes how the bank was configured.

Top module: `evc_bank`

## Requirements
- R1: After reset every count, snapshot, threshold, condition select, enable bit and active flag is zero, the index reads 0 and `irq_o` is low.
- R2: The register offsets are: 0 index, 1 condition select, 2 command, 3 count low word, 4 count high word, 5 threshold low word, 6 threshold high word, 7 enable mask, 8 active flags, 9 build word. Accesses at offsets 1, 3, 4, 5 and 6 reach only the counter named by the index; the other counters are unchanged.
- R3: A counter adds one in every cycle in which input `cond_i[sel]` is high, where sel is its condition select. The counter is 48 bits wide and wraps to zero past all ones. Writes to offsets 3 and 4 load bits 31:0 and bits 47:32 of the count.
- R4: Writing a 1 to bit 17 of the command register copies every live count into its snapshot. Reads at offsets 3 and 4 return the selected snapshot, not the live count. Bits above bit 47 read as zero in both counts and thresholds.
- R5: Writing a 1 to bit 16 of the command register zeroes every count. A clear or a load in a cycle beats an increment in that cycle. A snapshot taken in the same write captures the values from before the clear.
- R6: When an increment makes a count equal its threshold and enable bit n is 1, active bit n sets at that same clock edge. The bit does not set when the enable is 0, and it does not set when the count reaches the threshold by a load.
- R7: Writing 1 to bit n of the active register clears active bit n and enable bit n. Writing 0 to a bit leaves that bit alone.
- R8: `irq_o` is registered and is high exactly when at least one active bit is set. It updates at the same edge as the flags.
- R9: If a threshold match and a clearing write hit the same active bit in the same cycle, the match wins: the flag stays set and the enable stays set.
- R10: The build word at offset 9 reads version in bits 7:0 (0x02), size code 1 in bits 9:8, interrupt support 1 in bit 10, zero in bits 15:11, the counter count (4) in bits 23:16 and the condition-input count (8) in bits 31:24.
- R11: A read returns its data on `rdata_o` at the clock edge that samples `rd_en_i`, so the data is valid one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| cond_i | input | 8 | Event-condition inputs |
| irq_o | output | 1 | Combined threshold interrupt |

## Verification
The bench builds the block with its default parameters: four counters, 48-bit counts and eight condition inputs. This makes every pairing of counter and condition input small enough to sweep in full, each pairing driven with an arithmetic pulse pattern. A 48-bit wrap is reached by loading a count near its top. With four counters, several flags can be pending at once, so the bench can show that the interrupt line stays high until the last flag is cleared. It also drives a threshold match in the same cycle as a clear of that flag.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam logic [3:0] OFS_SEL    = 4'd0;
  localparam logic [3:0] OFS_EVSEL  = 4'd1;
  localparam logic [3:0] OFS_CMD    = 4'd2;
  localparam logic [3:0] OFS_CNTLO  = 4'd3;
  localparam logic [3:0] OFS_CNTHI  = 4'd4;
  localparam logic [3:0] OFS_THRLO  = 4'd5;
  localparam logic [3:0] OFS_THRHI  = 4'd6;
  localparam logic [3:0] OFS_IEN    = 4'd7;
  localparam logic [3:0] OFS_IACT   = 4'd8;
  localparam logic [3:0] OFS_BUILD  = 4'd9;

  localparam int CMD_CLR_BIT  = 16;
  localparam int CMD_SNAP_BIT = 17;

  function automatic logic [31:0] build_word(input int ver, input int sz,
                                             input int ncnt, input int ncond);
    logic [31:0] w;
    w        = '0;
    w[7:0]   = 8'(ver);
    w[9:8]   = 2'(sz);
    w[10]    = 1'b1;
    w[23:16] = 8'(ncnt);
    w[31:24] = 8'(ncond);
    return w;
  endfunction
endpackage

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
#(
  parameter int CW       = 48,
  parameter int NUM_COND = 8,
  parameter int ESW      = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_COND-1:0] cond_i,
  input  logic                we_i,
  input  logic [3:0]          addr_i,
  input  logic [31:0]         wdata_i,
  input  logic                clr_all_i,
  input  logic                snap_i,
  output logic [CW-1:0]       snap_o,
  output logic [CW-1:0]       thr_o,
  output logic [ESW-1:0]      evsel_o,
  output logic                hit_o
);
  logic [CW-1:0]  cnt_q, cnt_d, snap_q, thr_q, inc_val;
  logic [ESW-1:0] evsel_q;
  logic           ld_lo, ld_hi, inc_take;

  assign ld_lo   = we_i && (addr_i == OFS_CNTLO);
  assign ld_hi   = we_i && (addr_i == OFS_CNTHI);
  assign inc_val = cnt_q + CW'(1);

  always_comb begin
    cnt_d    = cnt_q;
    inc_take = 1'b0;
    if (clr_all_i)  cnt_d = '0;
    else if (ld_lo) cnt_d = CW'({32'(64'(cnt_q) >> 32), wdata_i});
    else if (ld_hi) cnt_d = CW'({wdata_i, cnt_q[31:0]});
    else if (cond_i[evsel_q]) begin
      cnt_d    = inc_val;
      inc_take = 1'b1;
    end
  end

  assign hit_o = inc_take && (inc_val == thr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      snap_q  <= '0;
      thr_q   <= '0;
      evsel_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (snap_i) snap_q <= cnt_q;
      if (we_i && addr_i == OFS_EVSEL) evsel_q <= wdata_i[ESW-1:0];
      if (we_i && addr_i == OFS_THRLO) thr_q <= CW'({32'(64'(thr_q) >> 32), wdata_i});
      if (we_i && addr_i == OFS_THRHI) thr_q <= CW'({wdata_i, thr_q[31:0]});
    end
  end

  assign snap_o  = snap_q;
  assign thr_o   = thr_q;
  assign evsel_o = evsel_q;

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr_all_i && !ld_lo && !ld_hi && cond_i[evsel_q]) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  assert_clear_all_R5: assert property (@(posedge clk) disable iff (rst)
    clr_all_i |=> (cnt_q == '0));

  assert_snapshot_R4: assert property (@(posedge clk) disable iff (rst)
    snap_i |=> (snap_q == $past(cnt_q)));
endmodule

// File: rtl/evc_irq.sv
module evc_irq #(
  parameter int NUM_CNT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] hit_i,
  input  logic               en_wr_i,
  input  logic               act_wr_i,
  input  logic [NUM_CNT-1:0] wmask_i,
  output logic [NUM_CNT-1:0] en_o,
  output logic [NUM_CNT-1:0] act_o,
  output logic               irq_o
);
  logic [NUM_CNT-1:0] en_q, act_q, set_v, clr_v, act_d, en_d;
  logic               irq_q;

  always_comb begin
    set_v = hit_i & en_q;
    clr_v = (act_wr_i ? wmask_i : '0) & ~set_v;
    act_d = set_v | (act_q & ~clr_v);
    en_d  = en_wr_i ? wmask_i : (en_q & ~clr_v);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      act_q <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      act_q <= act_d;
      irq_q <= |act_d;
    end
  end

  assign en_o  = en_q;
  assign act_o = act_q;
  assign irq_o = irq_q;

  assert_irq_matches_flags_R8: assert property (@(posedge clk) disable iff (rst)
    irq_q == (act_q != '0));

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_chk
    assert_flag_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
      (act_q[n] && !$past(act_q[n])) |-> $past(en_q[n] && hit_i[n]));

    assert_clear_drops_enable_R7: assert property (@(posedge clk) disable iff (rst)
      (act_wr_i && wmask_i[n] && !(hit_i[n] && en_q[n])) |=> (!act_q[n] && !en_q[n]));

    assert_match_wins_R9: assert property (@(posedge clk) disable iff (rst)
      (act_wr_i && wmask_i[n] && hit_i[n] && en_q[n]) |=> (act_q[n] && en_q[n]));
  end
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int NUM_CNT   = 4,
  parameter int SIZE_CODE = 1,
  parameter int NUM_COND  = 8,
  parameter int VERSION   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [3:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_COND-1:0] cond_i,
  output logic                irq_o
);
  localparam int CW   = 32 + 16 * SIZE_CODE;
  localparam int IDXW = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam int ESW  = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;
  localparam logic [31:0] BUILD = build_word(VERSION, SIZE_CODE, NUM_CNT, NUM_COND);

  logic [IDXW-1:0]    sel_q;
  logic [CW-1:0]      snap_arr [NUM_CNT];
  logic [CW-1:0]      thr_arr  [NUM_CNT];
  logic [ESW-1:0]     evsel_arr[NUM_CNT];
  logic [NUM_CNT-1:0] hit_v, en_v, act_v;
  logic               clr_all, snap_all;
  logic [31:0]        rdata_q, rd_d;
  logic [63:0]        snap64, thr64;

  assign clr_all  = wr_en_i && (addr_i == OFS_CMD) && wdata_i[CMD_CLR_BIT];
  assign snap_all = wr_en_i && (addr_i == OFS_CMD) && wdata_i[CMD_SNAP_BIT];

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (wr_en_i && addr_i == OFS_SEL) sel_q <= wdata_i[IDXW-1:0];
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    evc_counter #(.CW(CW), .NUM_COND(NUM_COND), .ESW(ESW)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .cond_i    (cond_i),
      .we_i      (wr_en_i && (sel_q == IDXW'(g))),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .clr_all_i (clr_all),
      .snap_i    (snap_all),
      .snap_o    (snap_arr[g]),
      .thr_o     (thr_arr[g]),
      .evsel_o   (evsel_arr[g]),
      .hit_o     (hit_v[g])
    );
  end

  evc_irq #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .hit_i    (hit_v),
    .en_wr_i  (wr_en_i && addr_i == OFS_IEN),
    .act_wr_i (wr_en_i && addr_i == OFS_IACT),
    .wmask_i  (wdata_i[NUM_CNT-1:0]),
    .en_o     (en_v),
    .act_o    (act_v),
    .irq_o    (irq_o)
  );

  assign snap64 = 64'(snap_arr[sel_q]);
  assign thr64  = 64'(thr_arr[sel_q]);

  always_comb begin
    case (addr_i)
      OFS_SEL:   rd_d = 32'(sel_q);
      OFS_EVSEL: rd_d = 32'(evsel_arr[sel_q]);
      OFS_CNTLO: rd_d = snap64[31:0];
      OFS_CNTHI: rd_d = snap64[63:32];
      OFS_THRLO: rd_d = thr64[31:0];
      OFS_THRHI: rd_d = thr64[63:32];
      OFS_IEN:   rd_d = 32'(en_v);
      OFS_IACT:  rd_d = 32'(act_v);
      OFS_BUILD: rd_d = BUILD;
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;

  assert_index_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    32'(sel_q) < NUM_CNT);

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == OFS_BUILD) |=> (rdata_o == BUILD));
endmodule

// File: tb/tb_evc_bank.sv
module tb_evc_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  cond = '0;
  logic        irq;
  int          chk = 0, fails = 0;
  bit          done = 1'b0;

  localparam logic [3:0] A_SEL = 0, A_EVS = 1, A_CMD = 2, A_CLO = 3, A_CHI = 4,
                         A_TLO = 5, A_THI = 6, A_IEN = 7, A_ACT = 8, A_BLD = 9;

  always #5 clk = ~clk;

  evc_bank dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cond_i(cond), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    chk++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int c, input int k);
    cond[c] = 1'b1;
    repeat (k) @(negedge clk);
    cond[c] = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int c, input int t);
    return 8'((t * 29 + c * 13 + 7) ^ (t >> 1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", chk, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int exp_cnt [4];
    int last2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R10 / R11: reset state and build word
    rd(A_BLD, v); check("R10 R11 build word", v, 32'h0804_0502);
    rd(A_SEL, v); check("R1 index", v, 0);
    rd(A_IEN, v); check("R1 enables", v, 0);
    rd(A_ACT, v); check("R1 active", v, 0);
    rd(A_CLO, v); check("R1 snapshot", v, 0);
    rd(A_TLO, v); check("R1 threshold", v, 0);
    check("R1 irq", 32'(irq), 0);

    // R2 / R3 / R4: sweep every counter-condition pairing
    last2 = 0;
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 4; k++) begin
        wr(A_SEL, k);
        wr(A_EVS, (c + k) % 8);
        exp_cnt[k] = 0;
      end
      wr(A_CMD, 32'h1 << 16);
      for (int t = 0; t < 20; t++) begin
        cond = pat(c, t);
        for (int k = 0; k < 4; k++) exp_cnt[k] += int'(cond[(c + k) % 8]);
        @(negedge clk);
      end
      cond = '0;
      wr(A_CMD, 32'h1 << 17);
      for (int k = 0; k < 4; k++) begin
        wr(A_SEL, k);
        rd(A_CLO, v); check($sformatf("R3 R2 count c%0d k%0d", c, k), v, exp_cnt[k]);
        rd(A_EVS, v); check($sformatf("R2 condition select k%0d", k), v, (c + k) % 8);
      end
      last2 = exp_cnt[2];
    end

    // R3 / R4: load, stale snapshot, upper bits, 48-bit wrap
    wr(A_SEL, 2);
    wr(A_EVS, 0);
    wr(A_CHI, 32'hABCD_FFFF);
    wr(A_CLO, 32'hFFFF_FFFE);
    rd(A_CLO, v); check("R4 snapshot stale before command", v, last2);
    wr(A_CMD, 32'h1 << 17);
    rd(A_CHI, v); check("R4 high word width limited", v, 32'h0000_FFFF);
    rd(A_CLO, v); check("R3 loaded low word", v, 32'hFFFF_FFFE);
    pulse(0, 3);
    wr(A_CMD, 32'h1 << 17);
    rd(A_CLO, v); check("R3 wrap low", v, 1);
    rd(A_CHI, v); check("R3 wrap high", v, 0);

    // R5: load beats increment
    cond[0] = 1'b1;
    wr(A_CLO, 100);
    cond[0] = 1'b0;
    wr(A_CMD, 32'h1 << 17);
    rd(A_CLO, v); check("R5 load over increment", v, 100);
    // R5: clear and snapshot together capture pre-clear value
    wr(A_CLO, 7);
    wr(A_CMD, 32'h3 << 16);
    rd(A_CLO, v); check("R5 snapshot before clear", v, 7);
    wr(A_CMD, 32'h1 << 17);
    rd(A_CLO, v); check("R5 clear all", v, 0);

    // R6 / R7 / R8: thresholds and flags
    wr(A_CMD, 32'h1 << 16);
    wr(A_SEL, 0); wr(A_EVS, 1); wr(A_TLO, 3); wr(A_THI, 0);
    wr(A_SEL, 1); wr(A_EVS, 1); wr(A_TLO, 5); wr(A_THI, 0);
    wr(A_SEL, 3); wr(A_EVS, 1); wr(A_TLO, 5); wr(A_THI, 32'h1234_0000);
    rd(A_THI, v); check("R4 threshold high width limited", v, 0);
    wr(A_IEN, 32'h3);
    pulse(1, 2);
    check("R8 irq low below threshold", 32'(irq), 0);
    pulse(1, 1);
    check("R6 R8 irq on match", 32'(irq), 1);
    rd(A_ACT, v); check("R6 counter0 flag", v, 32'h1);
    pulse(1, 2);
    rd(A_ACT, v); check("R6 counter1 flag, counter3 disabled", v, 32'h3);
    wr(A_ACT, 0);
    rd(A_ACT, v); check("R7 zero write no effect", v, 32'h3);
    wr(A_ACT, 32'h1);
    rd(A_ACT, v); check("R7 clear bit0", v, 32'h2);
    rd(A_IEN, v); check("R7 enable auto cleared", v, 32'h2);
    check("R8 irq held by remaining flag", 32'(irq), 1);
    wr(A_ACT, 32'h2);
    check("R8 irq low after last clear", 32'(irq), 0);
    rd(A_IEN, v); check("R7 enables all cleared", v, 0);

    // R6: reaching threshold by load does not flag
    wr(A_IEN, 32'h2);
    wr(A_SEL, 1);
    wr(A_CLO, 5);
    rd(A_ACT, v); check("R6 load to threshold no flag", v, 0);

    // R9: match and clear in the same cycle
    wr(A_CLO, 4);
    pulse(1, 1);
    rd(A_ACT, v); check("R6 flag before R9 case", v, 32'h2);
    wr(A_CLO, 4);
    @(negedge clk);
    cond[1] = 1'b1; wr_en = 1'b1; addr = A_ACT; wdata = 32'h2;
    @(negedge clk);
    cond[1] = 1'b0; wr_en = 1'b0;
    rd(A_ACT, v); check("R9 match keeps flag", v, 32'h2);
    rd(A_IEN, v); check("R9 match keeps enable", v, 32'h2);
    check("R9 irq stays high", 32'(irq), 1);
    wr(A_ACT, 32'h2);
    rd(A_ACT, v); check("R7 final clear", v, 0);
    check("R8 final irq", 32'(irq), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", chk, fails);
    $finish;
  end
endmodule